// File: doc/BRIEF.md
# Phase-Aligned Peripheral Bus Cycle Sequencer

This block turns host-side requests into single accesses on a slow peripheral bus that is paced by its own phase clock, as used by 8-bit microprocessor-era devices. The phase clock arrives asynchronously. The block brings it into the system clock domain and uses its level to step through each access.

An access request carries a wait count, a 16-bit address/data word with a per-pin output-enable mask, two 3-bit control codes and a read flag. The block first lets a programmed number of whole phase-clock periods go by. During the low phase it then presents the first control code together with the word and mask. When the phase clock is high it samples the data pins if the access is a read, and it moves the control lines to the second code. It returns to idle once the clock falls again.

Two special operations use the same request port. A pause runs a normal timed cycle, but the control lines show only the deselect code and the data pins are left alone. A bus clear drives every data pin low as an output at once.

Top module: `phi_bus_sequencer`

## Requirements
- R1: While reset is held, and right after it is released, `bus_ctl` is 3'b110 (deselect), `bus_out` and `bus_oe` are zero, `rd_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only when idle. A request with `req_op` 0 (access) or 1 (pause) that is taken while `req_valid` and `req_ready` are both high lowers `req_ready` on the next cycle. `req_ready` rises again only after the phase clock falls following the access's high phase, which is falling edge D+2 counted from acceptance for a wait count D.
- R3: For a wait count D in `req_delay`, the first control code `req_ctl_a` appears on `bus_ctl` after falling edge D+1 of the phase clock counted from acceptance, before the next rising edge. A count of zero therefore uses the first complete period.
- R4: The word `req_word` and mask `req_dir` appear on `bus_out` and `bus_oe` in the same cycle as the first control code. They hold until a later access or clear changes them.
- R5: When `req_read` is set, the 8 low data pins `bus_din` are sampled while the phase clock is high, and `rd_data` is presented with a `rd_valid` pulse of exactly one cycle. A write produces no pulse.
- R6: During the high phase the control lines switch to `req_ctl_b` in the same cycle as any read result, and they keep that code after the access ends.
- R7: A pause (`req_op` = 1) runs the same timed cycle, but `bus_ctl` only ever changes to 3'b110. `bus_out` and `bus_oe` are unchanged, and no read result is produced.
- R8: A clear (`req_op` = 2) sets `bus_out` to all zeros and `bus_oe` to all ones on the next cycle. `req_ready` stays high and `bus_ctl` is unchanged.
- R9: `req_op` = 3 is a no-op. Every output holds its value and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phi_in | input | 1 | Asynchronous bus phase clock |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_op | input | 2 | 0 access, 1 pause, 2 clear, 3 no-op |
| req_delay | input | 16 | Whole phase periods to wait minus one |
| req_word | input | 16 | Address/data pin values |
| req_dir | input | 16 | Per-pin output enable |
| req_ctl_a | input | 3 | Control code for the low phase |
| req_ctl_b | input | 3 | Control code from the high phase on |
| req_read | input | 1 | Sample data pins during the high phase |
| bus_din | input | 8 | Data pins as read back |
| bus_out | output | 16 | Address/data pin drive values |
| bus_oe | output | 16 | Address/data pin output enables |
| bus_ctl | output | 3 | Control lines |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Read result |

## Verification
The assertions assume that the phase clock is much slower than the system clock, so that each phase level lasts well beyond the synchronizer latency. They also assume that `bus_din` is stable for the whole high phase of a read. The stimulus runs the phase clock at one twentieth of the system rate and places its edges away from system clock edges. It issues every request a few cycles into a high phase, so the fall count measured at the pins is unambiguous. It holds `bus_din` constant across each access.

// File: rtl/bseq_pkg.sv
// Shared types for the phase-aligned bus sequencer.
// Assumes: the control field is 3 bits wide.
package bseq_pkg;
    typedef enum logic [1:0] {
        OP_ACCESS = 2'd0,
        OP_PAUSE  = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_NONE   = 2'd3
    } bseq_op_e;

    localparam int          CTL_W    = 3;
    localparam logic [2:0]  CTL_IDLE = 3'b110;
endpackage

// File: rtl/bseq_phase_sync.sv
// Synchronizes the asynchronous bus phase clock into the system clock domain.
// Assumes: the phase clock stays at each level for more than STAGES+1 system cycles.
module bseq_phase_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi_async,
    output logic phi_lvl
);
    logic [STAGES-1:0] chain;

    // Shift the raw phase level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], phi_async};
    end

    assign phi_lvl = chain[STAGES-1];
endmodule

// File: rtl/bseq_delay.sv
// Counts whole phase-clock periods (high level, then low level) after a start
// pulse. It emits a registered one-cycle fire pulse once count+1 periods have passed.
// Assumes: start comes only when the previous count has fired.
module bseq_delay #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] count,
    input  logic             phi_lvl,
    output logic             fire
);
    logic [DLY_W-1:0] remain;
    logic             active;
    logic             seen_high;

    // Load, then walk each period by waiting for a high level and then a low level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            active    <= 1'b0;
            seen_high <= 1'b0;
            fire      <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start) begin
                remain    <= count;
                active    <= 1'b1;
                seen_high <= 1'b0;
            end else if (active) begin
                if (!seen_high) begin
                    if (phi_lvl) seen_high <= 1'b1;
                end else if (!phi_lvl) begin
                    seen_high <= 1'b0;
                    if (remain == '0) begin
                        active <= 1'b0;
                        fire   <= 1'b1;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bseq_engine.sv
// Request acceptance and bus-phase state machine. It latches a request, starts
// the delay counter, drives the first control code and the data pins when
// the counter fires, and applies the second code and samples read data in the high phase.
// Assumes: fire arrives while the phase clock is low.
module bseq_engine
    import bseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RD_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi_lvl,
    input  logic              fire,
    output logic              dly_start,
    input  logic              req_valid,
    output logic              req_ready,
    input  bseq_op_e          req_op,
    input  logic [DATA_W-1:0] req_word,
    input  logic [DATA_W-1:0] req_dir,
    input  logic [CTL_W-1:0]  req_ctl_a,
    input  logic [CTL_W-1:0]  req_ctl_b,
    input  logic              req_read,
    input  logic [RD_W-1:0]   bus_din,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    output logic [CTL_W-1:0]  bus_ctl,
    output logic              rd_valid,
    output logic [RD_W-1:0]   rd_data
);
    typedef enum logic [1:0] {S_IDLE, S_DELAY, S_HIGH, S_LOW} state_e;

    state_e            state;
    logic [DATA_W-1:0] lat_word;
    logic [DATA_W-1:0] lat_dir;
    logic [CTL_W-1:0]  lat_a;
    logic [CTL_W-1:0]  lat_b;
    logic              lat_read;
    logic              lat_pause;
    logic              timed_op;

    // Decide whether the offered request needs a timed bus cycle.
    always_comb begin
        timed_op  = (req_op == OP_ACCESS) || (req_op == OP_PAUSE);
        req_ready = (state == S_IDLE);
        dly_start = req_ready && req_valid && timed_op;
    end

    // Sequence the bus phases and own every bus-facing register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            lat_word  <= '0;
            lat_dir   <= '0;
            lat_a     <= CTL_IDLE;
            lat_b     <= CTL_IDLE;
            lat_read  <= 1'b0;
            lat_pause <= 1'b0;
            bus_out   <= '0;
            bus_oe    <= '0;
            bus_ctl   <= CTL_IDLE;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        if (timed_op) begin
                            lat_pause <= (req_op == OP_PAUSE);
                            lat_word  <= req_word;
                            lat_dir   <= req_dir;
                            lat_a     <= (req_op == OP_PAUSE) ? CTL_IDLE : req_ctl_a;
                            lat_b     <= (req_op == OP_PAUSE) ? CTL_IDLE : req_ctl_b;
                            lat_read  <= req_read && (req_op == OP_ACCESS);
                            state     <= S_DELAY;
                        end else if (req_op == OP_CLEAR) begin
                            bus_out <= '0;
                            bus_oe  <= '1;
                        end
                    end
                end
                S_DELAY: begin
                    if (fire) begin
                        bus_ctl <= lat_a;
                        if (!lat_pause) begin
                            bus_out <= lat_word;
                            bus_oe  <= lat_dir;
                        end
                        state <= S_HIGH;
                    end
                end
                S_HIGH: begin
                    if (phi_lvl) begin
                        bus_ctl <= lat_b;
                        if (lat_read) begin
                            rd_valid <= 1'b1;
                            rd_data  <= bus_din;
                        end
                        state <= S_LOW;
                    end
                end
                default: begin
                    if (!phi_lvl) state <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/phi_bus_sequencer.sv
// Top level: phase-clock synchronizer, period delay counter and bus engine.
// Assumes: phi_in is much slower than clk; bus_din is stable while phi_in is high.
module phi_bus_sequencer
    import bseq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DLY_W       = 16,
    parameter int RD_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi_in,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [DLY_W-1:0]  req_delay,
    input  logic [DATA_W-1:0] req_word,
    input  logic [DATA_W-1:0] req_dir,
    input  logic [CTL_W-1:0]  req_ctl_a,
    input  logic [CTL_W-1:0]  req_ctl_b,
    input  logic              req_read,
    input  logic [RD_W-1:0]   bus_din,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    output logic [CTL_W-1:0]  bus_ctl,
    output logic              rd_valid,
    output logic [RD_W-1:0]   rd_data
);
    logic     phi_lvl;
    logic     fire;
    logic     dly_start;
    bseq_op_e op_dec;

    // Map the raw op field onto the shared operation type.
    always_comb op_dec = bseq_op_e'(req_op);

    bseq_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi_async (phi_in),
        .phi_lvl   (phi_lvl)
    );

    bseq_delay #(.DLY_W(DLY_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dly_start),
        .count   (req_delay),
        .phi_lvl (phi_lvl),
        .fire    (fire)
    );

    bseq_engine #(.DATA_W(DATA_W), .RD_W(RD_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi_lvl   (phi_lvl),
        .fire      (fire),
        .dly_start (dly_start),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (op_dec),
        .req_word  (req_word),
        .req_dir   (req_dir),
        .req_ctl_a (req_ctl_a),
        .req_ctl_b (req_ctl_b),
        .req_read  (req_read),
        .bus_din   (bus_din),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .bus_ctl   (bus_ctl),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/bseq_checker.sv
// Protocol checker for phi_bus_sequencer, attached with bind.
// Assumes: the synchronized phase level is visible as phi_lvl in the top.
module bseq_checker
    import bseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [DATA_W-1:0] bus_out,
    input logic [DATA_W-1:0] bus_oe,
    input logic [CTL_W-1:0]  bus_ctl,
    input logic              rd_valid,
    input logic              phi_lvl
);
    logic pause_run;

    // Track whether a pause cycle is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                                               pause_run <= 1'b0;
        else if (req_valid && req_ready && req_op == 2'd1)        pause_run <= 1'b1;
        else if (req_ready)                                       pause_run <= 1'b0;
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 2'd0 || req_op == 2'd1)) |=> !req_ready);

    a_r5_read_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(phi_lvl));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r7_pause_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_run && !$stable(bus_ctl)) |-> (bus_ctl == CTL_IDLE));

    a_r8_clear_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd2) |=> (bus_out == '0 && bus_oe == '1 && req_ready));
endmodule

bind phi_bus_sequencer bseq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .bus_ctl   (bus_ctl),
    .rd_valid  (rd_valid),
    .phi_lvl   (phi_lvl)
);

// File: tb/phi_bus_sequencer_test.sv
module phi_bus_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi_in = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_delay = '0;
    logic [15:0] req_word = '0;
    logic [15:0] req_dir = '0;
    logic [2:0]  req_ctl_a = '0;
    logic [2:0]  req_ctl_b = '0;
    logic        req_read = 1'b0;
    logic [7:0]  bus_din = '0;
    logic [15:0] bus_out;
    logic [15:0] bus_oe;
    logic [2:0]  bus_ctl;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int fall_cnt = 0;
    int rd_cnt = 0;
    bit done = 1'b0;

    phi_bus_sequencer uut (
        .clk(clk), .rst_n(rst_n), .phi_in(phi_in),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_delay(req_delay), .req_word(req_word), .req_dir(req_dir),
        .req_ctl_a(req_ctl_a), .req_ctl_b(req_ctl_b), .req_read(req_read),
        .bus_din(bus_din), .bus_out(bus_out), .bus_oe(bus_oe),
        .bus_ctl(bus_ctl), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    initial begin
        #1;
        forever #50 phi_in = ~phi_in;
    end

    always @(negedge phi_in) fall_cnt++;
    always @(negedge clk) if (rd_valid) rd_cnt++;

    // Vector fields: delay, word, dir, ctl_a, ctl_b, read, din
    localparam int NV = 6;
    localparam logic [62:0] VEC [NV] = '{
        {16'd0, 16'h1234, 16'hFFFF, 3'b001, 3'b011, 1'b0, 8'h00},
        {16'd1, 16'h0018, 16'h00FF, 3'b010, 3'b100, 1'b1, 8'hA5},
        {16'd2, 16'hBEEF, 16'hF0F0, 3'b101, 3'b111, 1'b0, 8'h00},
        {16'd3, 16'h0041, 16'h0F0F, 3'b000, 3'b011, 1'b1, 8'h3C},
        {16'd0, 16'h8001, 16'h8001, 3'b100, 3'b001, 1'b0, 8'h00},
        {16'd5, 16'h55AA, 16'hFF00, 3'b011, 3'b010, 1'b1, 8'h81}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ctl(input logic [2:0] code, output bit hit);
        hit = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (bus_ctl == code) begin
                hit = 1'b1;
                break;
            end
        end
    endtask

    task automatic wait_ready(output bit hit);
        hit = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (req_ready) begin
                hit = 1'b1;
                break;
            end
        end
    endtask

    // Issue a timed request a few cycles into a high phase, counting falls from acceptance.
    task automatic issue(input logic [1:0] op, input logic [15:0] dly, input logic [15:0] w,
                         input logic [15:0] d, input logic [2:0] a, input logic [2:0] b,
                         input logic rd, input logic [7:0] din);
        @(posedge phi_in);
        repeat (3) @(negedge clk);
        req_op = op; req_delay = dly; req_word = w; req_dir = d;
        req_ctl_a = a; req_ctl_b = b; req_read = rd; bus_din = din;
        req_valid = 1'b1;
        @(posedge clk);
        fall_cnt = 0;
        rd_cnt = 0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        bit hit;
        logic [15:0] prev_out, prev_oe;
        repeat (4) @(negedge clk);
        // R1: values held in reset
        chk(bus_ctl == 3'b110 && bus_out == 0 && bus_oe == 0 && !rd_valid && req_ready,
            "R1 in reset", {bus_ctl, bus_oe[7:0]}, {3'b110, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_ctl == 3'b110 && bus_out == 0 && bus_oe == 0 && !rd_valid && req_ready,
            "R1 after release", {bus_ctl, bus_out}, {3'b110, 16'h0});

        for (int v = 0; v < NV; v++) begin
            logic [15:0] dl, wd, dr;
            logic [2:0]  ca, cb;
            logic        rdf;
            logic [7:0]  dn;
            {dl, wd, dr, ca, cb, rdf, dn} = VEC[v];
            issue(2'd0, dl, wd, dr, ca, cb, rdf, dn);
            chk(!req_ready, "R2 busy after accept", req_ready, 0);
            wait_ctl(ca, hit);
            chk(hit && fall_cnt == int'(dl) + 1, "R3 first code after D+1 falls", fall_cnt, dl + 1);
            chk(phi_in == 1'b0, "R3 first code in low phase", phi_in, 0);
            chk(bus_out == wd && bus_oe == dr, "R4 word and mask with first code", {bus_out, bus_oe}, {wd, dr});
            wait_ctl(cb, hit);
            chk(hit && phi_in == 1'b1, "R6 second code in high phase", {hit, phi_in}, 2'b11);
            if (rdf) chk(rd_valid && rd_data == dn, "R5 read result", {rd_valid, rd_data}, {1'b1, dn});
            wait_ready(hit);
            chk(hit && fall_cnt == int'(dl) + 2, "R2 ready after closing fall", fall_cnt, dl + 2);
            chk(rd_cnt == int'(rdf), "R5 pulse count", rd_cnt, rdf);
            chk(bus_ctl == cb && bus_out == wd && bus_oe == dr, "R4 R6 values hold",
                {bus_ctl, bus_out}, {cb, wd});
        end

        // R7: pause keeps data, only deselect code
        prev_out = bus_out; prev_oe = bus_oe;
        issue(2'd1, 16'd1, 16'hDEAD, 16'h1111, 3'b001, 3'b000, 1'b1, 8'h77);
        wait_ctl(3'b110, hit);
        chk(hit && fall_cnt == 2, "R7 pause code timing", fall_cnt, 2);
        wait_ready(hit);
        chk(hit && bus_ctl == 3'b110 && bus_out == prev_out && bus_oe == prev_oe,
            "R7 pause leaves data", {bus_ctl, bus_out}, {3'b110, prev_out});
        chk(rd_cnt == 0, "R7 no read on pause", rd_cnt, 0);

        // R8: clear bus
        @(negedge clk);
        req_op = 2'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_out == 16'h0 && bus_oe == 16'hFFFF && req_ready && bus_ctl == 3'b110,
            "R8 clear", {bus_out, bus_oe}, {16'h0, 16'hFFFF});

        // R9: reserved op is a no-op
        req_op = 2'd3; req_word = 16'h1357; req_dir = 16'h0; req_ctl_a = 3'b001; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (60) begin
            @(negedge clk);
            if (!req_ready || bus_out != 0 || bus_oe != 16'hFFFF || bus_ctl != 3'b110 || rd_valid) break;
        end
        chk(req_ready && bus_out == 0 && bus_oe == 16'hFFFF && bus_ctl == 3'b110 && !rd_valid,
            "R9 no-op", {bus_ctl, bus_oe}, {3'b110, 16'hFFFF});

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule